// File: doc/BRIEF.md
# SAR Conversion Controller

This block is the digital half of a 10-bit successive-approximation converter. Software programs a small control register with a power enable, a start request, a completion flag, a two-bit speed code and a three-bit channel number. When a start is accepted, the block drives the chosen channel number to an external analog multiplexer. It then spends a sampling interval with the DAC code held at zero. After that it runs ten bit trials, from the most significant bit down. Each trial presents a candidate code to an external DAC and reads back one comparator bit.

When the last trial ends, the block writes the answer into two result registers: the upper eight bits go into one and the lower two bits into the other. One cycle later it sets a sticky completion flag and releases the start bit. The flag, gated by an external interrupt-enable input, forms the interrupt request. Asserting the low-power input turns the converter off at once and abandons any conversion in progress.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After a synchronous reset, the control readback, both result outputs, `dac_code`, `sample_on`, `mux_sel` and `irq` are all zero.
- R2: The control word layout is: bit 0 power, bit 1 start, bit 2 done flag, bits 4:3 speed code, bits 7:5 channel. A write takes effect at the clock edge where `ctrl_we` is 1, and `ctrl_rdata` returns the stored fields in the same layout.
- R3: A start is accepted only when the block is idle, the same write leaves the power bit at 1 and `lowpwr` is 0. Any other start write is ignored: the start bit reads 0 after it, `sample_on` stays 0 and `dac_code` stays 0.
- R4: Speed codes 0, 1, 2 and 3 select a total time T of 640, 320, 160 and 80 clocks. Sampling lasts T/4 clocks, with `sample_on` high and `dac_code` 0. Each bit trial lasts 3T/40 clocks. The done flag reads 1 exactly T+1 clocks after the edge that accepted the start.
- R5: Trials run from bit 9 down to bit 0. During a trial, `dac_code` equals the bits already kept with the current bit forced to 1. In the trial's last clock, the current bit is kept if `cmp_in` is 1 (input at or above the DAC output) and dropped otherwise.
- R6: The result is written one clock before the flag rises. Bits 9:2 go to `res_hi` and bits 1:0 to `res_lo[1:0]`, with `res_lo[7:2]` held at 0. With an ideal comparator, the result equals the analog input code.
- R7: Once set, the done flag stays 1 until software writes 0 to it. The start bit returns to 0 at the same edge where the flag is set.
- R8: `irq` is 1 exactly when the done flag is 1 and `irq_en` is 1.
- R9: While `lowpwr` is 1, the power and start bits are forced to 0 and a running conversion is abandoned. The flag is not set by it, and the result outputs keep their previous values.
- R10: During a conversion, `mux_sel` holds the channel latched at start, even if the channel field is rewritten. When idle, it follows the channel field. A start write during a conversion neither restarts nor stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register readback |
| lowpwr | input | 1 | Idle or power-down request; forces the converter off |
| irq_en | input | 1 | Interrupt enable |
| cmp_in | input | 1 | Comparator output: 1 when input is at or above DAC |
| mux_sel | output | 3 | Analog multiplexer channel select |
| dac_code | output | 10 | Trial code to the DAC |
| sample_on | output | 1 | High during the sampling interval |
| res_hi | output | 8 | Result bits 9:2 |
| res_lo | output | 8 | Result bits 1:0 in bits 1:0, upper bits zero |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 10-bit result and a slowest total of 640 clocks. All four speed codes therefore run at their real lengths, up to 641 clocks from start to flag. Analog inputs of 0, 1, 512, 677 and 1023 exercise every keep-or-drop outcome of the trials, including the all-zero and all-one extremes. These values also cover the split between the high and low result registers.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int CHAN_W = 3;
    localparam int SPD_W  = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_TRIAL,
        PH_FINISH
    } phase_e;

    // Control word, LSB first: power, start, flag, speed, channel
    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [SPD_W-1:0]  speed;
        logic              flag;
        logic              start;
        logic              power;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Sampling share: one quarter of the selected total
    function automatic int unsigned sample_clks(int unsigned slow_total, logic [SPD_W-1:0] spd);
        return (slow_total >> spd) / 4;
    endfunction

    // One bit trial: 3/40 of the selected total (ten trials = 3/4)
    function automatic int unsigned trial_clks(int unsigned slow_total, logic [SPD_W-1:0] spd);
        return ((slow_total >> spd) * 3) / 40;
    endfunction

endpackage

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg
    import sar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  ctrl_t             wdata,
    input  logic              lowpwr,
    input  logic              busy,
    input  logic              done,
    output ctrl_t             cfg,
    output logic              go,
    output logic              kill,
    output logic [SPD_W-1:0]  conv_speed,
    output logic [CHAN_W-1:0] conv_chan
);

    logic pwr_nxt;

    always_comb begin
        pwr_nxt = !lowpwr && (we ? wdata.power : cfg.power);
        kill    = busy && !pwr_nxt;
        go      = !busy && we && wdata.start && pwr_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            conv_speed <= '0;
            conv_chan  <= '0;
        end else begin
            cfg.power <= pwr_nxt;
            if (we) begin
                cfg.chan  <= wdata.chan;
                cfg.speed <= wdata.speed;
                cfg.flag  <= wdata.flag;
            end
            if (done)
                cfg.flag <= 1'b1;
            if (go)
                cfg.start <= 1'b1;
            else if (done || kill)
                cfg.start <= 1'b0;
            if (go) begin
                conv_speed <= wdata.speed;
                conv_chan  <= wdata.chan;
            end
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cfg.flag && !(we && !wdata.flag)) |=> cfg.flag); // R7

    AST_START_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst)
        (!busy && we && wdata.start && (lowpwr || !wdata.power)) |=> !cfg.start); // R3

    AST_LOWPWR_OFF: assert property (@(posedge clk) disable iff (rst)
        lowpwr |=> (!cfg.power && !cfg.start)); // R9

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int SLOW_TOTAL = 640,
    parameter int RES_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             kill,
    input  logic [SPD_W-1:0] speed,
    output phase_e           phase,
    output logic [$clog2(RES_W)-1:0] bit_idx,
    output logic             trial_last,
    output logic             load,
    output logic             done,
    output logic             busy
);

    localparam int CNT_W = $clog2(SLOW_TOTAL / 4 + 1);
    localparam int IDX_W = $clog2(RES_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] samp_end;
    logic [CNT_W-1:0] trial_end;
    logic             samp_last;

    always_comb begin
        samp_end   = CNT_W'(sample_clks(SLOW_TOTAL, speed) - 1);
        trial_end  = CNT_W'(trial_clks(SLOW_TOTAL, speed) - 1);
        busy       = (phase != PH_IDLE);
        samp_last  = (phase == PH_SAMPLE) && (cnt == samp_end);
        trial_last = (phase == PH_TRIAL) && (cnt == trial_end);
        load       = trial_last && (bit_idx == '0);
        done       = (phase == PH_FINISH) && !kill;
    end

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase <= PH_SAMPLE;
                        cnt   <= '0;
                    end
                end
                PH_SAMPLE: begin
                    if (samp_last) begin
                        phase   <= PH_TRIAL;
                        cnt     <= '0;
                        bit_idx <= IDX_W'(RES_W - 1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TRIAL: begin
                    if (trial_last) begin
                        cnt <= '0;
                        if (bit_idx == '0)
                            phase <= PH_FINISH;
                        else
                            bit_idx <= bit_idx - 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_FINISH: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_FINISH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FINISH) |=> (phase == PH_IDLE)); // R4

    AST_NO_GO_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !kill && phase != PH_FINISH) |=> busy); // R10

endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  phase_e           phase,
    input  logic [$clog2(RES_W)-1:0] bit_idx,
    input  logic             trial_last,
    input  logic             commit,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-3:0] res_hi,
    output logic [1:0]       res_lo
);

    logic [RES_W-1:0] acc;
    logic [RES_W-1:0] acc_nxt;
    logic [RES_W-1:0] trial_bit;

    always_comb begin
        trial_bit = RES_W'(1) << bit_idx;
        dac_code  = (phase == PH_TRIAL) ? (acc | trial_bit) : '0;
        acc_nxt   = acc;
        if (trial_last)
            acc_nxt[bit_idx] = cmp_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            res_hi <= '0;
            res_lo <= '0;
        end else begin
            if (go)
                acc <= '0;
            else if (trial_last)
                acc <= acc_nxt;
            if (commit) begin
                res_hi <= acc_nxt[RES_W-1:2];
                res_lo <= acc_nxt[1:0];
            end
        end
    end

    AST_LOWER_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL) |-> ((dac_code & (trial_bit - 1'b1)) == '0)); // R5

    AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL) |-> ($countones(dac_code & trial_bit) == 1)); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(res_hi) && $stable(res_lo))); // R6

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int SLOW_TOTAL = 640,
    parameter int RES_W      = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_we,
    input  logic [CTRL_W-1:0]     ctrl_wdata,
    output logic [CTRL_W-1:0]     ctrl_rdata,
    input  logic                  lowpwr,
    input  logic                  irq_en,
    input  logic                  cmp_in,
    output logic [CHAN_W-1:0]     mux_sel,
    output logic [RES_W-1:0]      dac_code,
    output logic                  sample_on,
    output logic [RES_W-3:0]      res_hi,
    output logic [7:0]            res_lo,
    output logic                  irq
);

    localparam int IDX_W = $clog2(RES_W);

    ctrl_t             cfg;
    logic              go;
    logic              kill;
    logic              busy;
    logic              done;
    logic              trial_last;
    logic              load;
    logic [SPD_W-1:0]  conv_speed;
    logic [CHAN_W-1:0] conv_chan;
    logic [IDX_W-1:0]  bit_idx;
    logic [1:0]        res_lo2;
    phase_e            phase;

    sar_ctrl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .we         (ctrl_we),
        .wdata      (ctrl_t'(ctrl_wdata)),
        .lowpwr     (lowpwr),
        .busy       (busy),
        .done       (done),
        .cfg        (cfg),
        .go         (go),
        .kill       (kill),
        .conv_speed (conv_speed),
        .conv_chan  (conv_chan)
    );

    sar_sequencer #(
        .SLOW_TOTAL (SLOW_TOTAL),
        .RES_W      (RES_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .kill       (kill),
        .speed      (conv_speed),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .trial_last (trial_last),
        .load       (load),
        .done       (done),
        .busy       (busy)
    );

    sar_search #(
        .RES_W (RES_W)
    ) u_sar (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .phase      (phase),
        .bit_idx    (bit_idx),
        .trial_last (trial_last),
        .commit     (load && !kill),
        .cmp_in     (cmp_in),
        .dac_code   (dac_code),
        .res_hi     (res_hi),
        .res_lo     (res_lo2)
    );

    always_comb begin
        ctrl_rdata = cfg;
        mux_sel    = busy ? conv_chan : cfg.chan;
        sample_on  = (phase == PH_SAMPLE);
        res_lo     = {6'b0, res_lo2};
        irq        = cfg.flag && irq_en;
    end

    AST_FLAG_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> cfg.flag); // R7

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq); // R8

    AST_IDLE_DAC_ZERO: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (dac_code == '0 && !sample_on)); // R3

endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wd = 8'h00;
    logic       lowpwr = 1'b0;
    logic       irq_en = 1'b0;
    int         vin = 0;

    logic [7:0] ctrl_rdata;
    logic [2:0] mux_sel;
    logic [9:0] dac_code;
    logic       sample_on;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       irq;
    logic       cmp;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    // external comparator: input at or above DAC output
    assign cmp = (vin >= int'(dac_code));

    sar_conv_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (we),
        .ctrl_wdata (wd),
        .ctrl_rdata (ctrl_rdata),
        .lowpwr     (lowpwr),
        .irq_en     (irq_en),
        .cmp_in     (cmp),
        .mux_sel    (mux_sel),
        .dac_code   (dac_code),
        .sample_on  (sample_on),
        .res_hi     (res_hi),
        .res_lo     (res_lo),
        .irq        (irq)
    );

    // ---------------- behavioural reference ----------------
    int m_pow, m_start, m_flag, m_spd, m_chan;
    int m_busy, m_t, m_acc, m_res, m_cspd, m_cchan;

    function automatic int tot(int s); return 640 >> s; endfunction

    always @(posedge clk) begin
        int pn, kl, dn, go, tt, ss, pp, b;
        if (rst) begin
            m_pow = 0; m_start = 0; m_flag = 0; m_spd = 0; m_chan = 0;
            m_busy = 0; m_t = 0; m_acc = 0; m_res = 0; m_cspd = 0; m_cchan = 0;
        end else begin
            pn = (!lowpwr && (we ? int'(wd[0]) : m_pow)) ? 1 : 0;
            kl = (m_busy != 0 && pn == 0) ? 1 : 0;
            tt = tot(m_cspd); ss = tt / 4; pp = tt * 3 / 40;
            dn = (m_busy != 0 && m_t == tt && kl == 0) ? 1 : 0;
            if (m_busy != 0 && kl == 0 && m_t >= ss && m_t < ss + 10 * pp
                && ((m_t - ss) % pp) == pp - 1) begin
                b = 9 - (m_t - ss) / pp;
                if (vin >= (m_acc | (1 << b))) m_acc = m_acc | (1 << b);
                if (b == 0) m_res = m_acc;
            end
            go = (m_busy == 0 && we && wd[1] && pn != 0) ? 1 : 0;
            m_pow = pn;
            if (we) begin
                m_flag = int'(wd[2]); m_spd = int'(wd[4:3]); m_chan = int'(wd[7:5]);
            end
            if (dn != 0) m_flag = 1;
            if (go != 0) m_start = 1;
            else if (dn != 0 || kl != 0) m_start = 0;
            if (go != 0) begin
                m_busy = 1; m_t = 0; m_acc = 0;
                m_cspd = int'(wd[4:3]); m_cchan = int'(wd[7:5]);
            end else if (kl != 0 || dn != 0) begin
                m_busy = 0;
            end else if (m_busy != 0) begin
                m_t = m_t + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(posedge clk) begin
        int tt, ss, pp, e_dac, e_ctrl;
        #2;
        tt = tot(m_cspd); ss = tt / 4; pp = tt * 3 / 40;
        e_dac = (m_busy != 0 && m_t >= ss && m_t < tt)
                ? (m_acc | (1 << (9 - (m_t - ss) / pp))) : 0;
        e_ctrl = (m_chan << 5) | (m_spd << 3) | (m_flag << 2) | (m_start << 1) | m_pow;
        chk(int'(ctrl_rdata) == e_ctrl, "R2 ctrl", int'(ctrl_rdata), e_ctrl);
        chk(int'(dac_code) == e_dac, "R5 dac", int'(dac_code), e_dac);
        chk(int'(sample_on) == ((m_busy != 0 && m_t < ss) ? 1 : 0), "R4 sample_on",
            int'(sample_on), (m_busy != 0 && m_t < ss) ? 1 : 0);
        chk(int'(res_hi) == (m_res >> 2), "R6 res_hi", int'(res_hi), m_res >> 2);
        chk(int'(res_lo) == (m_res & 3), "R6 res_lo", int'(res_lo), m_res & 3);
        chk(int'(mux_sel) == (m_busy != 0 ? m_cchan : m_chan), "R10 mux_sel",
            int'(mux_sel), m_busy != 0 ? m_cchan : m_chan);
        chk(int'(irq) == ((m_flag != 0 && irq_en) ? 1 : 0), "R8 irq",
            int'(irq), (m_flag != 0 && irq_en) ? 1 : 0);
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [7:0] cw(int pw, int st, int fl, int sp, int ch);
        return {3'(ch), 2'(sp), 1'(fl), 1'(st), 1'(pw)};
    endfunction

    task automatic wr(input logic [7:0] v);
        @(negedge clk); we = 1'b1; wd = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic run_conv(input int sp, input int ch, input int v);
        int n;
        vin = v;
        wr(cw(1, 1, 0, sp, ch));
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); n++; #2;
            if (ctrl_rdata[2]) break;
        end
        chk(n == tot(sp) + 1, "R4 flag latency", n, tot(sp) + 1);
        chk(int'(res_hi) == (v >> 2), "R6 high part", int'(res_hi), v >> 2);
        chk(int'(res_lo) == (v & 3), "R6 low part", int'(res_lo), v & 3);
        chk(ctrl_rdata[1] == 1'b0, "R7 start self-clear", int'(ctrl_rdata[1]), 0);
        wr(cw(1, 0, 0, sp, ch));
        chk(ctrl_rdata[2] == 1'b0, "R7 flag cleared by write", int'(ctrl_rdata[2]), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_rdata == 8'h00 && res_hi == 8'h00 && res_lo == 8'h00, "R1 regs",
            int'(ctrl_rdata), 0);
        chk(dac_code == 10'd0 && !sample_on && !irq && mux_sel == 3'd0, "R1 outputs",
            int'(dac_code), 0);

        // R3 start without power is ignored
        wr(cw(0, 1, 0, 2, 4));
        repeat (3) @(negedge clk);
        chk(ctrl_rdata[1] == 1'b0, "R3 start ignored", int'(ctrl_rdata[1]), 0);
        chk(!sample_on && dac_code == 10'd0, "R3 no conversion", int'(sample_on), 0);
        chk(mux_sel == 3'd4, "R10 idle mux follows field", int'(mux_sel), 4);

        // R3 start during lowpwr is ignored
        @(negedge clk); lowpwr = 1'b1; we = 1'b1; wd = cw(1, 1, 0, 3, 1);
        @(negedge clk); we = 1'b0; lowpwr = 1'b0;
        chk(ctrl_rdata[1:0] == 2'b00, "R3 lowpwr blocks start", int'(ctrl_rdata[1:0]), 0);

        // R4/R6/R7 conversion at fastest speed, then irq checks (R8)
        run_conv(3, 5, 677);
        wr(cw(1, 1, 0, 3, 5));
        repeat (85) @(negedge clk);
        chk(ctrl_rdata[2] == 1'b1, "R7 flag set", int'(ctrl_rdata[2]), 1);
        repeat (10) @(negedge clk);
        chk(ctrl_rdata[2] == 1'b1, "R7 flag sticky", int'(ctrl_rdata[2]), 1);
        chk(irq == 1'b0, "R8 irq masked", int'(irq), 0);
        @(negedge clk); irq_en = 1'b1;
        #1 chk(irq == 1'b1, "R8 irq enabled", int'(irq), 1);
        wr(cw(1, 0, 0, 3, 5));
        chk(irq == 1'b0, "R8 irq drops with flag", int'(irq), 0);
        irq_en = 1'b0;

        run_conv(1, 3, 0);
        run_conv(2, 6, 512);
        run_conv(3, 0, 1);

        // R10 mid-conversion channel rewrite and start writes
        vin = 1023;
        wr(cw(1, 1, 0, 0, 2));
        repeat (50) @(negedge clk);
        wr(cw(1, 0, 0, 0, 7));
        chk(mux_sel == 3'd2, "R10 channel latched", int'(mux_sel), 2);
        chk(ctrl_rdata[1] == 1'b1, "R10 start write 0 does not stop", int'(ctrl_rdata[1]), 1);
        wr(cw(1, 1, 0, 0, 7));
        repeat (700) @(negedge clk);
        chk(ctrl_rdata[2] == 1'b1 && res_hi == 8'hFF && res_lo == 8'h03, "R6 full scale",
            int'({res_hi, res_lo[1:0]}), 1023);
        chk(mux_sel == 3'd7, "R10 idle mux after done", int'(mux_sel), 7);
        wr(cw(1, 0, 0, 2, 7));

        // R5 first trial code and R9 abandon
        vin = 300;
        wr(cw(1, 1, 0, 2, 1));
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #2;
            if (!sample_on) break;
        end
        chk(dac_code == 10'd512, "R5 first trial is MSB", int'(dac_code), 512);
        repeat (30) @(negedge clk);
        lowpwr = 1'b1;
        @(negedge clk); lowpwr = 1'b0;
        chk(ctrl_rdata[1:0] == 2'b00, "R9 power and start off", int'(ctrl_rdata[1:0]), 0);
        chk(dac_code == 10'd0 && !sample_on, "R9 conversion abandoned", int'(dac_code), 0);
        repeat (200) @(negedge clk);
        chk(ctrl_rdata[2] == 1'b0, "R9 no flag", int'(ctrl_rdata[2]), 0);
        chk(res_hi == 8'hFF && res_lo == 8'h03, "R9 result kept",
            int'({res_hi, res_lo[1:0]}), 1023);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule